// File: doc/BRIEF.md
# Register-Move Immediate Decoder

This block sits behind an instruction fetch buffer and decodes one narrow family of 64-bit move instructions. Each cycle it may be handed a window of up to sixteen instruction bytes, byte 0 first, with a valid flag. It skips a run of register-extension prefix bytes, identifies one of four move encodings, measures the instruction length and finds where the result goes: a register and its number, or memory. It also produces the 64-bit value to be written, widened from the immediate carried in the encoding.

Only the short register-immediate form under the 64-bit operand-size bit carries a full eight-byte immediate. The encodings that use the addressing byte always carry four immediate bytes. Under 64-bit operand size those bytes are sign-extended. Under 32-bit operand size they are zero-extended, matching the rule that a 32-bit register write clears the upper half. An instruction longer than fifteen bytes is flagged. Results are registered and appear one cycle after the input, together with an output strobe.

Top module: `mov_imm_decoder`

## Requirements
- R1: While reset is held and until the first valid input after reset, `out_valid` is 0. Every registered output reads 0 after reset.
- R2: `out_valid` in a cycle equals `in_valid` in the previous cycle. Every result output keeps its value through cycles that follow an idle cycle.
- R3: An opcode byte 0xB8 to 0xBF is a register-only form with no addressing byte. The destination number is {REX.B, opcode bits 2:0}, `out_dst_mem` is 0 and `out_has_imm` is 1.
- R4: For the short form with REX.W set (prefix bit 3), the length is the prefix count plus 9. The value is the eight following bytes, least significant byte first.
- R5: With REX.W clear, the short form has length prefix count plus 5. For the short form and for 0xC7, the four immediate bytes are zero-extended to 64 bits.
- R6: Opcode 0xC7 with addressing-byte bits 5:3 equal to 0 carries exactly four immediate bytes after its addressing bytes. When REX.W is set these are sign-extended from bit 31.
- R7: Addressing bytes are counted as follows. The addressing byte is 1 byte. A scale-index byte is added when bits 7:6 are not 11 and bits 2:0 are 100. Bits 7:6 = 01 add 1 displacement byte and 10 add 4. Bits 7:6 = 00 add 4 when bits 2:0 are 101, or when the scale-index byte has bits 2:0 = 101.
- R8: For 0xC7 and 0x89, bits 7:6 = 11 give register destination {REX.B, bits 2:0}, and any other value gives a memory destination. For 0x8B the destination is always the register {REX.R (prefix bit 2), bits 5:3}. For 0x89 and 0x8B, `out_has_imm` is 0 and the value is 0.
- R9: Every byte 0x40 to 0x4F ahead of the opcode is a prefix that adds one byte to the length. Only the last one before the opcode supplies W, R and B.
- R10: `out_too_long` is 1 when a recognised instruction is longer than 15 bytes, or when the window holds only prefix bytes.
- R11: `out_illegal` is 1 for any opcode outside 0xB8 to 0xBF, 0xC7, 0x89 and 0x8B. It is also 1 for 0xC7 whose addressing-byte bits 5:3 are not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Window holds an instruction to decode |
| in_bytes | input | 128 | Instruction window, byte 0 in bits 7:0 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_illegal | output | 1 | Opcode or sub-opcode not supported |
| out_too_long | output | 1 | Length above the limit, or no opcode in window |
| out_len | output | 4 | Instruction length in bytes |
| out_dst_mem | output | 1 | Destination is memory |
| out_dst_reg | output | 4 | Destination register number (0 for memory) |
| out_has_imm | output | 1 | Encoding carries an immediate |
| out_value | output | 64 | Extended immediate to be written |

## Verification
A wrong prefix count or wrong last-prefix choice shows at the ports in the very next output cycle. It appears as a length off by the number of prefixes, or as the wrong extension and register bank. An error in the addressing-byte rules moves the immediate's start, so the value is garbled and the length is wrong in that same cycle. A clock-enable fault on the result registers shows only after an idle cycle, as outputs that change when no new input was accepted. The bench therefore mixes back-to-back and idle-separated inputs.

// File: rtl/mov_dec_pkg.sv
package mov_dec_pkg;

  localparam logic [4:0] OP_SHORT_TOP = 5'b10111;
  localparam logic [7:0] OP_RM_IMM    = 8'hC7;
  localparam logic [7:0] OP_STORE     = 8'h89;
  localparam logic [7:0] OP_LOAD      = 8'h8B;
  localparam logic [3:0] PFX_NIBBLE   = 4'h4;

  localparam int unsigned SHORT_IMM_NARROW = 4;
  localparam int unsigned SHORT_IMM_WIDE   = 8;
  localparam int unsigned RM_IMM_BYTES     = 4;

  typedef struct packed {
    logic w;
    logic r;
    logic b;
  } pfx_bits_t;

  typedef enum logic [2:0] {
    FORM_NONE,
    FORM_SHORT,
    FORM_RM_IMM,
    FORM_STORE,
    FORM_LOAD
  } form_e;

endpackage

// File: rtl/mov_pfx_scan.sv
module mov_pfx_scan
  import mov_dec_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 16,
  localparam int unsigned CNT_W = $clog2(WIN_BYTES + 1)
) (
  input  logic [WIN_BYTES*8-1:0] win,
  output logic [CNT_W-1:0]       pfx_cnt,
  output pfx_bits_t              pfx
);

  logic [WIN_BYTES-1:0] is_pfx;
  logic [WIN_BYTES-1:0] in_run;

  for (genvar gi = 0; gi < WIN_BYTES; gi++) begin : g_flag
    assign is_pfx[gi] = (win[gi*8+4 +: 4] == PFX_NIBBLE);
    if (gi == 0) begin : g_first
      assign in_run[gi] = is_pfx[gi];
    end else begin : g_rest
      assign in_run[gi] = in_run[gi-1] & is_pfx[gi];
    end
  end

  always_comb begin
    pfx_cnt = '0;
    pfx     = '0;
    for (int i = 0; i < WIN_BYTES; i++) begin
      if (in_run[i]) begin
        pfx_cnt = CNT_W'(i + 1);
        pfx.w   = win[i*8+3];
        pfx.r   = win[i*8+2];
        pfx.b   = win[i*8+0];
      end
    end
  end

endmodule

// File: rtl/mov_modrm_len.sv
module mov_modrm_len (
  input  logic [1:0] mod_f,
  input  logic [2:0] rm_f,
  input  logic [2:0] sib_base,
  output logic [2:0] addr_len,
  output logic       reg_direct
);

  logic       has_sib;
  logic [2:0] disp_len;

  always_comb begin
    reg_direct = (mod_f == 2'b11);
    has_sib    = !reg_direct && (rm_f == 3'b100);
    unique case (mod_f)
      2'b01:   disp_len = 3'd1;
      2'b10:   disp_len = 3'd4;
      2'b00: begin
        if (rm_f == 3'b101)                 disp_len = 3'd4;
        else if (has_sib && sib_base == 3'b101) disp_len = 3'd4;
        else                                disp_len = 3'd0;
      end
      default: disp_len = 3'd0;
    endcase
    addr_len = 3'd1 + {2'b00, has_sib} + disp_len;
  end

endmodule

// File: rtl/mov_imm_ext.sv
module mov_imm_ext #(
  parameter int unsigned WIN_BYTES = 16,
  parameter int unsigned IDX_W     = 6,
  localparam int unsigned VAL_W    = 64,
  localparam int unsigned HALF_W   = VAL_W / 2
) (
  input  logic [WIN_BYTES*8-1:0] win,
  input  logic [IDX_W-1:0]       offset,
  input  logic                   wide,
  input  logic                   sext,
  output logic [VAL_W-1:0]       value
);

  logic [VAL_W-1:0]  raw;
  logic [HALF_W-1:0] low;

  always_comb begin
    raw = VAL_W'(win >> {offset, 3'b000});
    low = raw[HALF_W-1:0];
    if (wide)      value = raw;
    else if (sext) value = {{HALF_W{low[HALF_W-1]}}, low};
    else           value = {{HALF_W{1'b0}}, low};
  end

endmodule

// File: rtl/mov_imm_decoder.sv
module mov_imm_decoder
  import mov_dec_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 16,
  parameter int unsigned MAX_LEN   = 15,
  localparam int unsigned CNT_W    = $clog2(WIN_BYTES + 1),
  localparam int unsigned IDX_W    = CNT_W + 1,
  localparam int unsigned SUM_W    = IDX_W + 1,
  localparam int unsigned LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [WIN_BYTES*8-1:0] in_bytes,
  output logic                   out_valid,
  output logic                   out_illegal,
  output logic                   out_too_long,
  output logic [LEN_W-1:0]       out_len,
  output logic                   out_dst_mem,
  output logic [3:0]             out_dst_reg,
  output logic                   out_has_imm,
  output logic [63:0]            out_value
);

  // reset: asynchronous assertion, synchronous release
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  logic arst_n;
  assign arst_n = rst_s2;

  // prefix run
  logic [CNT_W-1:0] pfx_cnt;
  pfx_bits_t        pfx;

  mov_pfx_scan #(.WIN_BYTES(WIN_BYTES)) u_scan (
    .win     (in_bytes),
    .pfx_cnt (pfx_cnt),
    .pfx     (pfx)
  );

  // byte picks
  logic [IDX_W-1:0] op_idx, am_idx, sib_idx;
  logic [7:0]       op_byte, am_byte;
  logic [2:0]       sib_base;
  logic             no_opcode;

  assign op_idx    = IDX_W'(pfx_cnt);
  assign am_idx    = op_idx + IDX_W'(1);
  assign sib_idx   = op_idx + IDX_W'(2);
  assign op_byte   = 8'(in_bytes >> {op_idx, 3'b000});
  assign am_byte   = 8'(in_bytes >> {am_idx, 3'b000});
  assign sib_base  = 3'(in_bytes >> {sib_idx, 3'b000});
  assign no_opcode = (pfx_cnt == CNT_W'(WIN_BYTES));

  // addressing length
  logic [2:0] addr_len;
  logic       reg_direct;

  mov_modrm_len u_alen (
    .mod_f      (am_byte[7:6]),
    .rm_f       (am_byte[2:0]),
    .sib_base   (sib_base),
    .addr_len   (addr_len),
    .reg_direct (reg_direct)
  );

  // form classification
  form_e form;
  always_comb begin
    form = FORM_NONE;
    if (!no_opcode) begin
      if (op_byte[7:3] == OP_SHORT_TOP)                      form = FORM_SHORT;
      else if (op_byte == OP_RM_IMM && am_byte[5:3] == 3'd0) form = FORM_RM_IMM;
      else if (op_byte == OP_STORE)                          form = FORM_STORE;
      else if (op_byte == OP_LOAD)                           form = FORM_LOAD;
    end
  end

  logic is_short, is_rm_imm, is_store, is_load, illegal_nx;
  assign is_short   = (form == FORM_SHORT);
  assign is_rm_imm  = (form == FORM_RM_IMM);
  assign is_store   = (form == FORM_STORE);
  assign is_load    = (form == FORM_LOAD);
  assign illegal_nx = !no_opcode && (form == FORM_NONE);

  // length
  logic [SUM_W-1:0] body_len, total_len;
  logic             too_long_nx;

  always_comb begin
    unique case (form)
      FORM_SHORT:  body_len = SUM_W'(1 + (pfx.w ? SHORT_IMM_WIDE : SHORT_IMM_NARROW));
      FORM_RM_IMM: body_len = SUM_W'(1 + RM_IMM_BYTES) + SUM_W'(addr_len);
      FORM_STORE,
      FORM_LOAD:   body_len = SUM_W'(1) + SUM_W'(addr_len);
      default:     body_len = '0;
    endcase
    total_len   = SUM_W'(pfx_cnt) + body_len;
    too_long_nx = no_opcode || (!illegal_nx && (total_len > SUM_W'(MAX_LEN)));
  end

  // destination
  logic       dst_mem_nx;
  logic [3:0] dst_reg_nx;

  always_comb begin
    dst_mem_nx = (is_rm_imm || is_store) && !reg_direct;
    unique case (form)
      FORM_SHORT:  dst_reg_nx = {pfx.b, op_byte[2:0]};
      FORM_RM_IMM,
      FORM_STORE:  dst_reg_nx = dst_mem_nx ? 4'd0 : {pfx.b, am_byte[2:0]};
      FORM_LOAD:   dst_reg_nx = {pfx.r, am_byte[5:3]};
      default:     dst_reg_nx = 4'd0;
    endcase
  end

  // immediate
  logic [IDX_W-1:0] imm_off;
  logic [63:0]      imm_val, value_nx;
  logic             has_imm_nx;

  assign imm_off    = is_short ? am_idx : am_idx + IDX_W'(addr_len);
  assign has_imm_nx = is_short || is_rm_imm;

  mov_imm_ext #(.WIN_BYTES(WIN_BYTES), .IDX_W(IDX_W)) u_imm (
    .win    (in_bytes),
    .offset (imm_off),
    .wide   (is_short && pfx.w),
    .sext   (is_rm_imm && pfx.w),
    .value  (imm_val)
  );

  assign value_nx = has_imm_nx ? imm_val : 64'd0;

  // result registers
  logic             valid_q, illegal_q, too_long_q, dst_mem_q, has_imm_q;
  logic [LEN_W-1:0] len_q;
  logic [3:0]       dst_reg_q;
  logic [63:0]      value_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      illegal_q  <= 1'b0;
      too_long_q <= 1'b0;
      len_q      <= '0;
      dst_mem_q  <= 1'b0;
      dst_reg_q  <= 4'd0;
      has_imm_q  <= 1'b0;
      value_q    <= 64'd0;
    end else if (in_valid) begin
      illegal_q  <= illegal_nx;
      too_long_q <= too_long_nx;
      len_q      <= LEN_W'(total_len);
      dst_mem_q  <= dst_mem_nx;
      dst_reg_q  <= dst_reg_nx;
      has_imm_q  <= has_imm_nx;
      value_q    <= value_nx;
    end
  end

  assign out_valid    = valid_q;
  assign out_illegal  = illegal_q;
  assign out_too_long = too_long_q;
  assign out_len      = len_q;
  assign out_dst_mem  = dst_mem_q;
  assign out_dst_reg  = dst_reg_q;
  assign out_has_imm  = has_imm_q;
  assign out_value    = value_q;

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!arst_n)
    in_valid |=> out_valid);

  // R2
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !in_valid |=> !out_valid);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !in_valid |=> ($stable(out_value) && $stable(out_len) && $stable(out_dst_reg)));

  // R3
  short_reg_only_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && is_short) |=> (!out_dst_mem && out_has_imm));

  // R5
  narrow_zext_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && has_imm_nx && !pfx.w) |=> (out_value[63:32] == 32'd0));

  // R6
  rm_imm_sext_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && is_rm_imm && pfx.w) |=> (out_value[63:32] == {32{out_value[31]}}));

  // R8
  load_reg_dst_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && is_load) |=> (!out_dst_mem && !out_has_imm && out_value == 64'd0));

  // R11
  illegal_excl_chk: assert property (@(posedge clk) disable iff (!arst_n)
    out_valid |-> !(out_illegal && out_too_long));

endmodule

// File: tb/mov_imm_decoder_tb.sv
module mov_imm_decoder_tb;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_bytes;
  logic         out_valid, out_illegal, out_too_long, out_dst_mem, out_has_imm;
  logic [3:0]   out_len, out_dst_reg;
  logic [63:0]  out_value;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  mov_imm_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_too_long(out_too_long),
    .out_len(out_len), .out_dst_mem(out_dst_mem), .out_dst_reg(out_dst_reg),
    .out_has_imm(out_has_imm), .out_value(out_value)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gb(input logic [127:0] w, input int i);
    if (i < 16) return w[i*8 +: 8];
    return 8'h00;
  endfunction

  function automatic int addr_bytes(input logic [7:0] m, input logic [7:0] s);
    int cnt = 1;
    bit sib = (m[7:6] != 2'b11) && (m[2:0] == 3'b100);
    if (sib) cnt += 1;
    if (m[7:6] == 2'b01) cnt += 1;
    else if (m[7:6] == 2'b10) cnt += 4;
    else if (m[7:6] == 2'b00) begin
      if (m[2:0] == 3'b101) cnt += 4;
      else if (sib && s[2:0] == 3'b101) cnt += 4;
    end
    return cnt;
  endfunction

  function automatic logic [63:0] le_bytes(input logic [127:0] w, input int at, input int cnt);
    logic [63:0] v = '0;
    for (int k = 0; k < cnt; k++) v[k*8 +: 8] = gb(w, at + k);
    return v;
  endfunction

  task automatic model(input logic [127:0] w,
                       output bit ill, output bit tl, output int len,
                       output bit mem, output logic [3:0] rg, output bit hi,
                       output logic [63:0] val, output string ltag, output string vtag);
    int n = 0;
    logic [7:0] px, op, m;
    int al;
    ill = 0; tl = 0; len = 0; mem = 0; rg = 0; hi = 0; val = 0;
    ltag = "R7"; vtag = "R5";
    while (n < 16 && gb(w, n) >= 8'h40 && gb(w, n) <= 8'h4F) n++;
    if (n == 16) begin tl = 1; return; end
    px = (n > 0) ? gb(w, n-1) : 8'h00;
    op = gb(w, n);
    m  = gb(w, n+1);
    al = addr_bytes(m, gb(w, n+2));
    if (op >= 8'hB8 && op <= 8'hBF) begin
      hi = 1; rg = {px[0], op[2:0]};
      if (px[3]) begin
        len = n + 9; val = le_bytes(w, n+1, 8); ltag = "R4"; vtag = "R4";
      end else begin
        len = n + 5; val = le_bytes(w, n+1, 4); ltag = "R5"; vtag = "R5";
      end
    end else if (op == 8'hC7) begin
      if (m[5:3] != 3'd0) begin ill = 1; return; end
      hi = 1; len = n + 1 + al + 4;
      mem = (m[7:6] != 2'b11);
      rg = mem ? 4'd0 : {px[0], m[2:0]};
      val = le_bytes(w, n+1+al, 4);
      if (px[3]) begin
        val[63:32] = {32{val[31]}}; vtag = "R6";
      end
    end else if (op == 8'h89 || op == 8'h8B) begin
      len = n + 1 + al; vtag = "R8";
      if (op == 8'h89) begin
        mem = (m[7:6] != 2'b11);
        rg = mem ? 4'd0 : {px[0], m[2:0]};
      end else begin
        rg = {px[2], m[5:3]};
      end
    end else begin
      ill = 1; return;
    end
    tl = (len > 15);
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic run(input logic [127:0] w, input string ctx);
    bit ill, tl, mem, hi;
    int len;
    logic [3:0] rg;
    logic [63:0] val;
    string lt, vt;
    model(w, ill, tl, len, mem, rg, hi, val, lt, vt);
    in_valid = 1'b1;
    in_bytes = w;
    @(negedge clk);
    chk("R2", {ctx, " strobe"}, 64'(out_valid), 64'd1);
    chk("R11", {ctx, " illegal"}, 64'(out_illegal), 64'(ill));
    if (!ill) chk("R10", {ctx, " too_long"}, 64'(out_too_long), 64'(tl));
    if (!ill && !tl) begin
      chk(lt, {ctx, " length"}, 64'(out_len), 64'(len));
      chk("R8", {ctx, " dst_mem"}, 64'(out_dst_mem), 64'(mem));
      if (!mem) chk("R3", {ctx, " dst_reg"}, 64'(out_dst_reg), 64'(rg));
      chk("R8", {ctx, " has_imm"}, 64'(out_has_imm), 64'(hi));
      chk(vt, {ctx, " value"}, out_value, val);
    end
  endtask

  function automatic logic [127:0] rand_win();
    logic [127:0] w;
    int n, pick;
    for (int i = 0; i < 4; i++) w[i*32 +: 32] = $urandom;
    n = (($urandom % 8) == 0) ? 4 + ($urandom % 12) : $urandom % 4;
    for (int i = 0; i < n; i++) w[i*8 +: 8] = 8'h40 | 8'($urandom % 16);
    pick = $urandom % 6;
    case (pick)
      0, 1: w[n*8 +: 8] = 8'hB8 | 8'($urandom % 8);
      2:    begin
              w[n*8 +: 8] = 8'hC7;
              if (($urandom % 5) != 0 && n < 15) w[(n+1)*8+3 +: 3] = 3'd0;
            end
      3:    w[n*8 +: 8] = 8'h89;
      4:    w[n*8 +: 8] = 8'h8B;
      default: ;
    endcase
    return w;
  endfunction

  function automatic logic [127:0] fill(input logic [127:0] base, input int at,
                                        input logic [63:0] v, input int cnt);
    logic [127:0] w = base;
    for (int k = 0; k < cnt; k++) w[(at+k)*8 +: 8] = v[k*8 +: 8];
    return w;
  endfunction

  initial begin
    logic [127:0] w;
    logic [63:0]  held;
    void'($urandom(32'h1D5E));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_bytes = '0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "valid after reset", 64'(out_valid), 64'd0);
    chk("R1", "value after reset", out_value, 64'd0);
    chk("R1", "len after reset", 64'(out_len), 64'd0);

    // R3 R5: REX.B short form, 32-bit immediate
    w = '0; w = fill(w, 0, 64'h12345678_BB41, 6);
    run(w, "short narrow");
    // R4: wide short form
    w = '0; w = fill(w, 0, 64'hB848, 2); w = fill(w, 2, 64'h0123456789ABCDEF, 8);
    run(w, "short wide");
    // R6: memory destination, all-ones immediate
    w = '0; w = fill(w, 0, 64'hFFFFFFFF_00C748, 7);
    run(w, "rm_imm mem");
    // R7: scale-index byte with base 101 under mod 00
    w = '0; w = fill(w, 0, 64'h25_04_C7_48, 4);
    w = fill(w, 4, 64'hDEADBEEF, 4); w = fill(w, 8, 64'h7FFFFFFF, 4);
    run(w, "sib disp32");
    // R6: register destination, negative immediate
    w = '0; w = fill(w, 0, 64'h80000000_C1C748, 7);
    run(w, "rm_imm reg neg");
    // R5: 0xC7 without REX.W zero-extends
    w = '0; w = fill(w, 0, 64'h80000000_C0C7, 6);
    run(w, "rm_imm narrow");
    // R11: sub-opcode not zero, and an unknown opcode
    w = '0; w = fill(w, 0, 64'h1111_C8C7, 4);
    run(w, "bad subop");
    w = '0; w = fill(w, 0, 64'h0F, 1);
    run(w, "bad opcode");
    // R9: only the last prefix counts
    w = '0; w = fill(w, 0, 64'hCAFEF00D_BA41_48, 7);
    run(w, "two prefixes");
    // R8: load to extended register, disp8
    w = '0; w = fill(w, 0, 64'h08_45_8B_4C, 4);
    run(w, "load");
    // R7 R8: store through scale-index with disp32
    w = '0; w = fill(w, 0, 64'h24_84_89, 3); w = fill(w, 3, 64'h100, 4);
    run(w, "store");
    // R10 boundary: 6 prefixes + wide short = 15, 7 prefixes = 16
    w = '0; for (int i = 0; i < 5; i++) w[i*8 +: 8] = 8'h40;
    w = fill(w, 5, 64'hB848, 2); w = fill(w, 7, 64'hA5A5A5A5A5A5A5A5, 8);
    run(w, "len 15");
    w = '0; for (int i = 0; i < 6; i++) w[i*8 +: 8] = 8'h40;
    w = fill(w, 6, 64'hB848, 2); w = fill(w, 8, 64'h5A5A5A5A5A5A5A5A, 8);
    run(w, "len 16");
    w = '0; for (int i = 0; i < 16; i++) w[i*8 +: 8] = 8'h4F;
    run(w, "all prefix");

    // R2: idle cycles keep results
    w = '0; w = fill(w, 0, 64'h00C0FFEE_B9, 5);
    run(w, "before idle");
    held = out_value;
    in_valid = 1'b0;
    in_bytes = ~128'd0;
    @(negedge clk);
    chk("R2", "strobe idle", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk("R2", "value held", out_value, held);
    chk("R2", "len held", 64'(out_len), 64'd5);

    for (int t = 0; t < 600; t++) begin
      run(rand_win(), "random");
      if (($urandom % 4) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2", "random idle", 64'(out_valid), 64'd0);
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule